// File: doc/BRIEF.md
# SCSI Initiator Message-Out Sequencer

When a target moves the bus into the message-out phase, this block decides which bytes the initiator sends and sends them one at a time. The pending message code is captured when `start` is pulsed. The IDENTIFY code makes the block form an IDENTIFY byte from the logical unit and the disconnect permission. If tagging is enabled, a two-byte queue-tag message follows that byte. The host-message code hands the turn to the host through an interrupt. Any other code goes out as a single one-byte message.

Each byte leaves on a valid/ready handshake. After the target takes a byte, the block waits for `phase_strobe`, which marks the target's next request, and reads the bus phase. If the target leaves message-out after a non-final byte, the remaining bytes are dropped. If it stays in message-out after the final byte, the message is resent from its first byte. ATN is lowered before the final byte is offered and raised again for a resend. At the end the block lowers ATN, records the code it handled, and asks the owner of the pending code to set it to no-operation.

Top module: `msgout_builder`

## Requirements
- R1: With pending code 0x80 on a narrow bus (`wide`=0), the first byte is 0x80 | (disc_en ? 0x40 : 0) | lun[2:0], and lun[3] has no effect.
- R2: With `wide`=1, the IDENTIFY byte takes all four logical-unit bits: 0x80 | (disc_en ? 0x40 : 0) | lun[3:0].
- R3: With `tag_en`=1 and `mk_msg`=0, three bytes are sent in this order: IDENTIFY, then 0x20 | tag_type, then tag_val.
- R4: After every byte that is not final, the phase is sampled on `phase_strobe`. If it is not message-out (3'b110), the sequence ends and no further byte is offered.
- R5: Pending code 0xFF raises `host_irq` for exactly one cycle, and no byte is offered until `host_rsp`. A response with `host_phase_chg`=1 ends the sequence with no byte sent. Otherwise `host_byte` is sent as the final byte.
- R6: `atn` is 0 whenever the final byte of a message is offered, and 1 whenever a non-final byte is offered.
- R7: If the phase is still message-out after the final byte is accepted, `atn` returns to 1 and the whole message is resent from its first byte.
- R8: On completion, a single cycle shows `done`=1, `clr_pending`=1 and `atn`=0, and `last_msg` then holds the captured pending code.
- R9: With code 0x80 and `mk_msg`=1, the IDENTIFY byte is sent with `atn` high. After it is accepted, the host-message path of R5 follows, with no phase check in between.
- R10: While `byte_valid`=1 and `byte_ready`=0, `byte_valid` stays 1 and `byte_data` stays stable.
- R11: Any pending code other than 0x80 and 0xFF is sent unchanged as a single final byte.
- R12: After reset, `atn`, `byte_valid`, `host_irq`, `done` and `clr_pending` are 0, and `last_msg` is 0x08 (no-operation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: target entered message-out; captures the inputs below |
| pend_code | input | 8 | Pending message code |
| lun | input | 4 | Logical unit number |
| disc_en | input | 1 | Disconnect permission for IDENTIFY |
| tag_en | input | 1 | Append the queue-tag message |
| tag_type | input | 2 | Queue-tag type (0 simple, 1 head, 2 ordered) |
| tag_val | input | 8 | Queue-tag value |
| mk_msg | input | 1 | After IDENTIFY, let the host supply a message |
| wide | input | 1 | Wide bus: 4-bit logical unit field |
| bus_phase | input | 3 | Current bus phase, message-out = 3'b110 |
| phase_strobe | input | 1 | Next target request seen; phase is valid |
| host_rsp | input | 1 | Host answered the interrupt |
| host_phase_chg | input | 1 | With host_rsp: host saw the phase change |
| host_byte | input | 8 | With host_rsp: byte supplied by the host |
| byte_data | output | 8 | Outgoing message byte |
| byte_valid | output | 1 | Byte offered |
| byte_ready | input | 1 | Byte accepted |
| atn | output | 1 | ATN request to the target |
| host_irq | output | 1 | One-cycle awaiting-message interrupt |
| done | output | 1 | One-cycle completion pulse |
| clr_pending | output | 1 | One-cycle request to set the pending code to no-operation |
| last_msg | output | 8 | Code of the last message handled |

## Verification
The assertions check on every cycle that a stalled byte keeps its value, that ATN matches whether the offered byte is final, that completion, a byte offer and the interrupt never occur in the same cycle, and that the interrupt and completion are single-cycle pulses. Only the bench's scenarios can show the byte values and their order for the different logical units, bus widths and tag settings. The same holds for the early exit when the phase changes, the full resend, and the two outcomes of the host path.

// File: rtl/msgout_pkg.sv
package msgout_pkg;
  localparam logic [7:0] IDENT_CODE  = 8'h80;
  localparam logic [7:0] NOP_CODE    = 8'h08;
  localparam logic [7:0] DISC_BIT    = 8'h40;
  localparam logic [7:0] TAGMSG_BASE = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISPATCH,
    ST_SEND,
    ST_CHECK,
    ST_NEXT,
    ST_HIRQ,
    ST_HWAIT
  } mo_state_t;
endpackage

// File: rtl/msgout_ident_fmt.sv
module msgout_ident_fmt
  import msgout_pkg::*;
#(
  parameter int LUN_W = 4,
  parameter int TT_W  = 2
) (
  input  logic [LUN_W-1:0] lun,
  input  logic             wide,
  input  logic             disc,
  input  logic [TT_W-1:0]  ttype,
  output logic [7:0]       ident_byte,
  output logic [7:0]       tag_byte
);
  localparam int TOP = LUN_W - 1;

  logic [7:0] lun_byte;
  logic [7:0] tt_byte;

  always_comb begin
    lun_byte = '0;
    lun_byte[LUN_W-1:0] = lun;
    if (!wide) lun_byte[TOP] = 1'b0;
    tt_byte = '0;
    tt_byte[TT_W-1:0] = ttype;
  end

  assign ident_byte = IDENT_CODE | (disc ? DISC_BIT : 8'h00) | lun_byte;
  assign tag_byte   = TAGMSG_BASE | tt_byte;
endmodule

// File: rtl/msgout_tx_port.sv
module msgout_tx_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              last,
  output logic              fire
);
  assign fire = valid & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      last  <= load_last;
    end else if (fire) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/msgout_builder.sv
module msgout_builder
  import msgout_pkg::*;
#(
  parameter int         LUN_W     = 4,
  parameter int         TT_W      = 2,
  parameter int         PHASE_W   = 3,
  parameter logic [2:0] MSGOUT_PH = 3'b110,
  parameter logic [7:0] HOST_CODE = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [7:0]         pend_code,
  input  logic [LUN_W-1:0]   lun,
  input  logic               disc_en,
  input  logic               tag_en,
  input  logic [TT_W-1:0]    tag_type,
  input  logic [7:0]         tag_val,
  input  logic               mk_msg,
  input  logic               wide,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic               phase_strobe,
  input  logic               host_rsp,
  input  logic               host_phase_chg,
  input  logic [7:0]         host_byte,
  output logic [7:0]         byte_data,
  output logic               byte_valid,
  input  logic               byte_ready,
  output logic               atn,
  output logic               host_irq,
  output logic               done,
  output logic               clr_pending,
  output logic [7:0]         last_msg
);
  localparam logic [1:0] STEP_IDENT = 2'd0;
  localparam logic [1:0] STEP_TTYPE = 2'd1;

  mo_state_t state;
  logic [7:0]       code_q, tval_q;
  logic [LUN_W-1:0] lun_q;
  logic [TT_W-1:0]  tt_q;
  logic             disc_q, tag_q, mk_q, wide_q, to_host_q;
  logic [1:0]       step_q;

  logic [7:0] ident_byte, tag_byte;
  logic       ld, ld_last, tx_fire, tx_last;
  logic [7:0] ld_data;
  logic       in_msgout;

  assign in_msgout = (bus_phase == MSGOUT_PH);

  msgout_ident_fmt #(.LUN_W(LUN_W), .TT_W(TT_W)) u_fmt (
    .lun(lun_q), .wide(wide_q), .disc(disc_q), .ttype(tt_q),
    .ident_byte(ident_byte), .tag_byte(tag_byte)
  );

  msgout_tx_port #(.DATA_W(8)) u_tx (
    .clk(clk), .rst(rst), .load(ld), .load_data(ld_data),
    .load_last(ld_last), .ready(byte_ready), .valid(byte_valid),
    .data(byte_data), .last(tx_last), .fire(tx_fire)
  );

  // Byte selection for the register stage
  always_comb begin
    ld      = 1'b0;
    ld_data = 8'h00;
    ld_last = 1'b0;
    unique case (state)
      ST_DISPATCH: begin
        if (code_q == IDENT_CODE) begin
          ld      = 1'b1;
          ld_data = ident_byte;
          ld_last = !(mk_q || tag_q);
        end else if (code_q != HOST_CODE) begin
          ld      = 1'b1;
          ld_data = code_q;
          ld_last = 1'b1;
        end
      end
      ST_NEXT: begin
        ld      = 1'b1;
        ld_data = (step_q == STEP_TTYPE) ? tag_byte : tval_q;
        ld_last = (step_q != STEP_TTYPE);
      end
      ST_HWAIT: begin
        if (host_rsp && !host_phase_chg) begin
          ld      = 1'b1;
          ld_data = host_byte;
          ld_last = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      code_q      <= NOP_CODE;
      tval_q      <= '0;
      lun_q       <= '0;
      tt_q        <= '0;
      disc_q      <= 1'b0;
      tag_q       <= 1'b0;
      mk_q        <= 1'b0;
      wide_q      <= 1'b0;
      to_host_q   <= 1'b0;
      step_q      <= STEP_IDENT;
      atn         <= 1'b0;
      host_irq    <= 1'b0;
      done        <= 1'b0;
      clr_pending <= 1'b0;
      last_msg    <= NOP_CODE;
    end else begin
      host_irq    <= 1'b0;
      done        <= 1'b0;
      clr_pending <= 1'b0;
      if (ld) begin
        state <= ST_SEND;
        if (ld_last) atn <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            code_q <= pend_code;
            lun_q  <= lun;
            disc_q <= disc_en;
            tag_q  <= tag_en;
            tt_q   <= tag_type;
            tval_q <= tag_val;
            mk_q   <= mk_msg;
            wide_q <= wide;
            atn    <= 1'b1;
            state  <= ST_DISPATCH;
          end
        end
        ST_DISPATCH: begin
          step_q    <= STEP_IDENT;
          to_host_q <= (code_q == IDENT_CODE) && mk_q;
          if (code_q == HOST_CODE) state <= ST_HIRQ;
        end
        ST_SEND: begin
          if (tx_fire) begin
            if (to_host_q) begin
              to_host_q <= 1'b0;
              state     <= ST_HIRQ;
            end else begin
              state <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (phase_strobe) begin
            if (tx_last && in_msgout) begin
              atn   <= 1'b1;
              state <= ST_DISPATCH;
            end else if (tx_last || !in_msgout) begin
              done        <= 1'b1;
              clr_pending <= 1'b1;
              atn         <= 1'b0;
              last_msg    <= code_q;
              state       <= ST_IDLE;
            end else begin
              step_q <= step_q + 2'd1;
              state  <= ST_NEXT;
            end
          end
        end
        ST_NEXT: ;
        ST_HIRQ: begin
          host_irq <= 1'b1;
          state    <= ST_HWAIT;
        end
        ST_HWAIT: begin
          if (host_rsp && host_phase_chg) begin
            done        <= 1'b1;
            clr_pending <= 1'b1;
            atn         <= 1'b0;
            last_msg    <= code_q;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msgout_builder_chk.sv
module msgout_builder_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_data,
  input logic       tx_last,
  input logic       atn,
  input logic       host_irq,
  input logic       done,
  input logic       clr_pending
);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  assert_atn_low_final_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && tx_last) |-> !atn);

  assert_atn_high_mid_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !tx_last) |-> atn);

  assert_done_clears_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!atn && clr_pending));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    host_irq |=> !host_irq);

  assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, byte_valid, host_irq}));

  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> (!byte_valid && !atn && !done && !host_irq));
endmodule

bind msgout_builder msgout_builder_chk u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_ready(byte_ready),
  .byte_data(byte_data), .tx_last(tx_last), .atn(atn), .host_irq(host_irq),
  .done(done), .clr_pending(clr_pending)
);

// File: tb/msgout_builder_tb.sv
module msgout_builder_tb;
  localparam logic [2:0] PH_MO = 3'b110;
  localparam logic [2:0] PH_ST = 3'b011;

  logic clk = 0, rst = 1, start = 0;
  logic [7:0] pend_code = 0, tag_val = 0, host_byte = 0;
  logic [3:0] lun = 0;
  logic disc_en = 0, tag_en = 0, mk_msg = 0, wide = 0;
  logic [1:0] tag_type = 0;
  logic [2:0] bus_phase = PH_MO;
  logic phase_strobe = 1, host_rsp = 0, host_phase_chg = 0, byte_ready = 0;
  logic [7:0] byte_data, last_msg;
  logic byte_valid, atn, host_irq, done, clr_pending;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  msgout_builder u_dut (
    .clk(clk), .rst(rst), .start(start), .pend_code(pend_code), .lun(lun),
    .disc_en(disc_en), .tag_en(tag_en), .tag_type(tag_type), .tag_val(tag_val),
    .mk_msg(mk_msg), .wide(wide), .bus_phase(bus_phase),
    .phase_strobe(phase_strobe), .host_rsp(host_rsp),
    .host_phase_chg(host_phase_chg), .host_byte(host_byte),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .atn(atn), .host_irq(host_irq), .done(done), .clr_pending(clr_pending),
    .last_msg(last_msg)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] code; logic [3:0] lun; logic disc; logic tag;
    logic [1:0] tt; logic [7:0] tval; logic wide; logic [1:0] n;
    logic [7:0] b0; logic [7:0] b1; logic [7:0] b2;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h80, 4'd5,  1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 2'd1, 8'hC5, 8'h00, 8'h00}, // R1
    '{8'h80, 4'hD,  1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd1, 8'h85, 8'h00, 8'h00}, // R1 lun[3] dropped
    '{8'h80, 4'hD,  1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 8'h8D, 8'h00, 8'h00}, // R2
    '{8'h80, 4'd2,  1'b1, 1'b1, 2'd1, 8'h3A, 1'b0, 2'd3, 8'hC2, 8'h21, 8'h3A}, // R3
    '{8'h80, 4'hF,  1'b1, 1'b1, 2'd2, 8'h00, 1'b1, 2'd3, 8'hCF, 8'h22, 8'h00}, // R3 R2
    '{8'h06, 4'd3,  1'b1, 1'b1, 2'd0, 8'h55, 1'b0, 2'd1, 8'h06, 8'h00, 8'h00}, // R11
    '{8'h0C, 4'd0,  1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 8'h0C, 8'h00, 8'h00}  // R11
  };

  task automatic kick(input logic [7:0] code);
    bus_phase = PH_MO;
    pend_code = code;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic recv(input logic [7:0] exp, input logic exp_atn, input logic leave,
                      input int hold, input string req);
    int n = 0;
    while (!byte_valid && n < 50) begin @(negedge clk); n++; end
    check(byte_valid, req, 32'(byte_valid), 1);
    check(byte_data == exp, req, 32'(byte_data), 32'(exp));
    check(atn == exp_atn, {req, " atn"}, 32'(atn), 32'(exp_atn));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(byte_valid && byte_data == exp, "R10 hold", 32'(byte_data), 32'(exp));
    end
    byte_ready = 1;
    if (leave) bus_phase = PH_ST;
    @(negedge clk);
    byte_ready = 0;
  endtask

  task automatic wait_done(input logic [7:0] exp_last, input string req);
    int n = 0;
    logic stray = 0;
    while (!done && n < 50) begin
      if (byte_valid) stray = 1;
      @(negedge clk); n++;
    end
    check(done, req, 32'(done), 1);
    check(!stray, {req, " no extra byte"}, 32'(stray), 0);
    check(!atn && clr_pending, {req, " atn/clr"}, {atn, clr_pending}, 32'h1);
    @(negedge clk);
    check(last_msg == exp_last, {req, " last_msg"}, 32'(last_msg), 32'(exp_last));
  endtask

  task automatic wait_irq(output logic seen, output logic stray);
    seen = 0; stray = 0;
    for (int i = 0; i < 20; i++) begin
      if (host_irq) seen = 1;
      if (byte_valid) stray = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    logic seen, stray;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!atn && !byte_valid && !host_irq && !done && !clr_pending, "R12",
          {atn, byte_valid, host_irq, done, clr_pending}, 0);
    check(last_msg == 8'h08, "R12 last_msg", 32'(last_msg), 32'h08);
    rst = 0;
    @(negedge clk);

    // table walk: R1 R2 R3 R6 R8 R11
    foreach (VECS[i]) begin
      lun = VECS[i].lun; disc_en = VECS[i].disc; tag_en = VECS[i].tag;
      tag_type = VECS[i].tt; tag_val = VECS[i].tval; wide = VECS[i].wide;
      mk_msg = 0;
      kick(VECS[i].code);
      for (int b = 0; b < int'(VECS[i].n); b++) begin
        logic fin;
        fin = (b == int'(VECS[i].n) - 1);
        recv(b == 0 ? VECS[i].b0 : (b == 1 ? VECS[i].b1 : VECS[i].b2),
             !fin, fin, (i == 3 && b == 1) ? 3 : 0, "R3/R1/R11 byte R6");
      end
      wait_done(VECS[i].code, "R8");
    end

    // R4: phase changes after IDENTIFY of a tagged message
    lun = 4'd1; disc_en = 0; tag_en = 1; tag_type = 0; tag_val = 8'h44; wide = 0;
    kick(8'h80);
    recv(8'h81, 1, 1, 0, "R4 ident");
    wait_done(8'h80, "R4 early exit");

    // R7: target stays in message-out after the final tag byte
    lun = 4'd2; disc_en = 1; tag_type = 2'd0; tag_val = 8'h10;
    kick(8'h80);
    recv(8'hC2, 1, 0, 0, "R7 first");
    recv(8'h20, 1, 0, 0, "R7 first");
    recv(8'h10, 0, 0, 0, "R7 first final");
    recv(8'hC2, 1, 0, 0, "R7 resend ident");
    recv(8'h20, 1, 0, 0, "R7 resend");
    recv(8'h10, 0, 1, 0, "R7 resend final");
    wait_done(8'h80, "R7 done");

    // R5: host code, host reports phase change
    tag_en = 0;
    kick(8'hFF);
    wait_irq(seen, stray);
    check(seen, "R5 irq", 32'(seen), 1);
    check(!stray, "R5 no byte before rsp", 32'(stray), 0);
    host_rsp = 1; host_phase_chg = 1;
    @(negedge clk);
    host_rsp = 0; host_phase_chg = 0;
    wait_done(8'hFF, "R5 phase change");

    // R5: host code, host supplies a byte
    kick(8'hFF);
    wait_irq(seen, stray);
    check(seen && !stray, "R5 irq", {seen, stray}, 32'h2);
    host_rsp = 1; host_byte = 8'h0F;
    @(negedge clk);
    host_rsp = 0;
    recv(8'h0F, 0, 1, 0, "R5 host byte");
    wait_done(8'hFF, "R5 host done");

    // R9: make-message flag after IDENTIFY
    lun = 4'd3; disc_en = 0; mk_msg = 1; tag_en = 1;
    kick(8'h80);
    recv(8'h83, 1, 0, 0, "R9 ident");
    wait_irq(seen, stray);
    check(seen && !stray, "R9 irq", {seen, stray}, 32'h2);
    host_rsp = 1; host_byte = 8'h07;
    @(negedge clk);
    host_rsp = 0;
    recv(8'h07, 0, 1, 0, "R9 host byte");
    wait_done(8'h80, "R9 done");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule